// File: doc/BRIEF.md
# VP Register Address Mapper

This block sits beside one cluster register file of one lane and turns a virtual-processor-relative register number into a physical index. The file has a fixed number of entries. It is split into two parts. The low part holds registers that every VP sees, which hold scratch values that only live for one instruction block. The high part is a run of equal-sized windows, one window per VP. The split is set by writing a shared count and a per-VP private count.

On each configuration write the block computes how many VP windows fit. It uses a registered restoring division that takes one quotient bit per clock. While that runs, a ready flag is low and translations are held quiet. A one-cycle pulse tells the surrounding logic that all VP register contents are now undefined.

A translation combines the VP slot number with a logical register number. Logical registers below the shared count pass through unchanged. The others land in the window of the requested slot. A slot with no window, or a register past the end of the configured set, raises an error and gives no valid index.

Top module: `vrm_reg_mapper`

## Requirements
- R1: After reset the configuration is 0 shared and 8 private, `vp_count` is 4, `cfg_ready` is 1 and `state_lost` is 0.
- R2: After a configuration write with shared count S and private count P, `vp_count` equals floor((32 − S) / P), limited to 128. It is 0 when P is 0 or S exceeds 32. It holds that value until the next write.
- R3: `cfg_ready` is 0 from the first edge after a write for 6 cycles and is 1 again after the 6th edge. A write during that time restarts the count of 6 cycles from the new write.
- R4: `state_lost` is 1 for exactly the one cycle that follows each clock edge at which `cfg_we` was sampled high, and 0 otherwise.
- R5: With the access in range, a logical register R below S gives `phys_idx` = R with `idx_valid` = 1.
- R6: With the access in range, a logical register R with S ≤ R < S + P for slot V gives `phys_idx` = S + V·P + (R − S) with `idx_valid` = 1.
- R7: If V ≥ `vp_count` or R ≥ S + P, then `acc_err` = 1, `idx_valid` = 0 and `phys_idx` = 0. `acc_err` and `idx_valid` are never 1 together.
- R8: While `cfg_ready` is 0, `idx_valid`, `acc_err` and `phys_idx` are all 0, whatever the access inputs are.
- R9: The translation outputs follow `vp_slot` and `log_reg` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_shared | input | 6 | Shared register count to load |
| cfg_private | input | 6 | Private registers per VP to load |
| vp_slot | input | 7 | VP slot of the access |
| log_reg | input | 5 | Logical register number of the access |
| phys_idx | output | 5 | Physical register-file index |
| idx_valid | output | 1 | Index is valid |
| acc_err | output | 1 | Access out of range |
| vp_count | output | 8 | Number of VPs the configuration supports |
| cfg_ready | output | 1 | VP count is computed and translation is enabled |
| state_lost | output | 1 | One-cycle pulse: VP register state undefined |

## Verification
Translation results are due in the same cycle as the access. The bench changes the access at a falling edge and samples a fraction of a nanosecond later, well before the next rising edge, and it sweeps slots up to one past the computed count against every logical register. For each configuration write, the bench counts falling edges after the sampling edge. It expects `state_lost` high and `cfg_ready` low after the first falling edge, `cfg_ready` still low after falling edges 2 to 6, and `cfg_ready` high with the new count after the seventh. That seventh falling edge follows the sixth division edge. A restart write made mid-division is timed the same way from the second write.

// File: rtl/vrm_pkg.sv
package vrm_pkg;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;

  // Number of private windows that fit after the shared part, capped.
  function automatic int vp_fit(int phys, int shared_cnt, int priv_cnt, int max_vps);
    int q;
    if (priv_cnt == 0 || shared_cnt > phys) return 0;
    q = (phys - shared_cnt) / priv_cnt;
    return (q > max_vps) ? max_vps : q;
  endfunction

endpackage

// File: rtl/vrm_cfg_regs.sv
module vrm_cfg_regs #(
  parameter int CFG_W       = 6,
  parameter int RST_SHARED  = 0,
  parameter int RST_PRIVATE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_shared,
  input  logic [CFG_W-1:0] wr_private,
  output logic [CFG_W-1:0] shared_q,
  output logic [CFG_W-1:0] private_q,
  output logic             lost_q
);

  logic [CFG_W-1:0] shared_d;
  logic [CFG_W-1:0] private_d;
  logic             lost_d;

  always_comb begin
    shared_d  = wr_shared;
    private_d = wr_private;
    lost_d    = wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shared_q  <= CFG_W'(RST_SHARED);
      private_q <= CFG_W'(RST_PRIVATE);
      lost_q    <= 1'b0;
    end else begin
      lost_q <= lost_d;
      if (wr_en) begin
        shared_q  <= shared_d;
        private_q <= private_d;
      end
    end
  end

endmodule

// File: rtl/vrm_vp_divider.sv
module vrm_vp_divider #(
  parameter int DW        = 6,
  parameter int CNT_W     = 8,
  parameter int MAX_VPS   = 128,
  parameter int RST_COUNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DW-1:0]    dividend,
  input  logic [DW-1:0]    divisor,
  output logic             ready,
  output logic [CNT_W-1:0] quotient
);
  import vrm_pkg::*;

  localparam int SCW = $clog2(DW + 1);
  localparam int XW  = CNT_W + DW;

  div_state_e       state_q, state_d;
  logic [DW:0]      rem_q, rem_d;
  logic [DW-1:0]    quo_q, quo_d;
  logic [DW-1:0]    dvs_q, dvs_d;
  logic [SCW-1:0]   steps_q, steps_d;
  logic [CNT_W-1:0] res_q, res_d;
  logic             clk_en;

  logic [DW:0]      trial;
  logic [DW:0]      rem_step;
  logic [DW-1:0]    quo_step;
  logic [XW-1:0]    quo_ext;
  logic             fits;

  // One restoring-division step: shift in the next dividend bit, try to subtract.
  always_comb begin
    trial    = {rem_q[DW-1:0], quo_q[DW-1]};
    fits     = (trial >= {1'b0, dvs_q});
    rem_step = fits ? (trial - {1'b0, dvs_q}) : trial;
    quo_step = {quo_q[DW-2:0], fits};
    quo_ext  = {{CNT_W{1'b0}}, quo_step};
  end

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    steps_d = steps_q;
    res_d   = res_q;
    if (start) begin
      state_d = DIV_RUN;
      rem_d   = '0;
      quo_d   = dividend;
      dvs_d   = divisor;
      steps_d = SCW'(DW);
    end else if (state_q == DIV_RUN) begin
      rem_d   = rem_step;
      quo_d   = quo_step;
      steps_d = steps_q - 1'b1;
      if (steps_q == SCW'(1)) begin
        state_d = DIV_IDLE;
        if (dvs_q == '0)
          res_d = '0;
        else if (quo_ext > XW'(MAX_VPS))
          res_d = CNT_W'(MAX_VPS);
        else
          res_d = quo_ext[CNT_W-1:0];
      end
    end
  end

  assign clk_en = start || (state_q == DIV_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DIV_IDLE;
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      steps_q <= '0;
      res_q   <= CNT_W'(RST_COUNT);
    end else if (clk_en) begin
      state_q <= state_d;
      rem_q   <= rem_d;
      quo_q   <= quo_d;
      dvs_q   <= dvs_d;
      steps_q <= steps_d;
      res_q   <= res_d;
    end
  end

  assign ready    = (state_q == DIV_IDLE);
  assign quotient = res_q;

  // R3: a start always takes the divider out of the ready state next cycle
  p_busy_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);

  // R2: the count does not move while idle and no write arrives
  p_hold_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> $stable(quotient));

endmodule

// File: rtl/vrm_addr_xlate.sv
module vrm_addr_xlate #(
  parameter int IDX_W  = 5,
  parameter int CFG_W  = 6,
  parameter int SLOT_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic              enable,
  input  logic [CFG_W-1:0]  shared_cnt,
  input  logic [CFG_W-1:0]  private_cnt,
  input  logic [CNT_W-1:0]  vp_limit,
  input  logic [SLOT_W-1:0] slot,
  input  logic [IDX_W-1:0]  lreg,
  output logic [IDX_W-1:0]  pidx,
  output logic              valid,
  output logic              err
);

  localparam int MW = SLOT_W + CFG_W + CNT_W + 1;

  logic [MW-1:0] slot_w, lreg_w, sh_w, pr_w, lim_w;
  logic [MW-1:0] window_idx;
  logic          slot_ok, reg_ok, is_shared;

  always_comb begin
    slot_w     = MW'(slot);
    lreg_w     = MW'(lreg);
    sh_w       = MW'(shared_cnt);
    pr_w       = MW'(private_cnt);
    lim_w      = MW'(vp_limit);
    slot_ok    = slot_w < lim_w;
    reg_ok     = lreg_w < (sh_w + pr_w);
    is_shared  = lreg_w < sh_w;
    window_idx = sh_w + slot_w * pr_w + (lreg_w - sh_w);

    pidx  = '0;
    valid = 1'b0;
    err   = 1'b0;
    if (enable) begin
      if (!(slot_ok && reg_ok)) begin
        err = 1'b1;
      end else begin
        valid = 1'b1;
        pidx  = is_shared ? lreg : window_idx[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/vrm_reg_mapper.sv
module vrm_reg_mapper #(
  parameter int PHYS_REGS   = 32,
  parameter int MAX_VPS     = 128,
  parameter int RST_SHARED  = 0,
  parameter int RST_PRIVATE = 8,
  localparam int IDX_W  = $clog2(PHYS_REGS),
  localparam int CFG_W  = IDX_W + 1,
  localparam int SLOT_W = $clog2(MAX_VPS),
  localparam int CNT_W  = $clog2(MAX_VPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_shared,
  input  logic [CFG_W-1:0]  cfg_private,
  input  logic [SLOT_W-1:0] vp_slot,
  input  logic [IDX_W-1:0]  log_reg,
  output logic [IDX_W-1:0]  phys_idx,
  output logic              idx_valid,
  output logic              acc_err,
  output logic [CNT_W-1:0]  vp_count,
  output logic              cfg_ready,
  output logic              state_lost
);

  localparam int RST_COUNT = vrm_pkg::vp_fit(PHYS_REGS, RST_SHARED, RST_PRIVATE, MAX_VPS);
  localparam int AW        = CNT_W + CFG_W + 1;

  logic [CFG_W-1:0] shared_q, private_q;
  logic [CFG_W-1:0] free_regs;

  vrm_cfg_regs #(
    .CFG_W      (CFG_W),
    .RST_SHARED (RST_SHARED),
    .RST_PRIVATE(RST_PRIVATE)
  ) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_shared (cfg_shared),
    .wr_private(cfg_private),
    .shared_q  (shared_q),
    .private_q (private_q),
    .lost_q    (state_lost)
  );

  // Registers left for private windows; none when the shared part overflows.
  logic [CFG_W-1:0] free_in;
  always_comb begin
    free_in   = (cfg_shared > CFG_W'(PHYS_REGS)) ? '0 : (CFG_W'(PHYS_REGS) - cfg_shared);
    free_regs = (shared_q > CFG_W'(PHYS_REGS)) ? '0 : (CFG_W'(PHYS_REGS) - shared_q);
  end

  vrm_vp_divider #(
    .DW       (CFG_W),
    .CNT_W    (CNT_W),
    .MAX_VPS  (MAX_VPS),
    .RST_COUNT(RST_COUNT)
  ) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (cfg_we),
    .dividend(free_in),
    .divisor (cfg_private),
    .ready   (cfg_ready),
    .quotient(vp_count)
  );

  vrm_addr_xlate #(
    .IDX_W (IDX_W),
    .CFG_W (CFG_W),
    .SLOT_W(SLOT_W),
    .CNT_W (CNT_W)
  ) xlate_i (
    .enable     (cfg_ready),
    .shared_cnt (shared_q),
    .private_cnt(private_q),
    .vp_limit   (vp_count),
    .slot       (vp_slot),
    .lreg       (log_reg),
    .pidx       (phys_idx),
    .valid      (idx_valid),
    .err        (acc_err)
  );

  // R4: every write is followed by the state-loss pulse
  p_lost_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> state_lost);

  // R4: no pulse without a write on the previous edge
  p_lost_only_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> !state_lost);

  // R2: the computed windows never overrun the file
  p_count_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ready && private_q != '0) |->
      (AW'(vp_count) * AW'(private_q) <= AW'(free_regs)));

  // R8: translation is quiet while the count is being computed
  p_quiet_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ready |-> (!idx_valid && !acc_err && phys_idx == '0));

  // R7: valid and error are exclusive
  p_valid_excl_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_valid && acc_err));

endmodule

// File: tb/vrm_reg_mapper_tb.sv
`timescale 1ns/100ps
module vrm_reg_mapper_tb_top;

  localparam int PHYS  = 32;
  localparam int MAXV  = 128;
  localparam int STEPS = 6;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [5:0] cfg_shared;
  logic [5:0] cfg_private;
  logic [6:0] vp_slot;
  logic [4:0] log_reg;
  logic [4:0] phys_idx;
  logic       idx_valid;
  logic       acc_err;
  logic [7:0] vp_count;
  logic       cfg_ready;
  logic       state_lost;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  vrm_reg_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_shared(cfg_shared),
    .cfg_private(cfg_private), .vp_slot(vp_slot), .log_reg(log_reg),
    .phys_idx(phys_idx), .idx_valid(idx_valid), .acc_err(acc_err),
    .vp_count(vp_count), .cfg_ready(cfg_ready), .state_lost(state_lost)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_count(input int s, input int p);
    int q;
    if (p == 0 || s > PHYS) return 0;
    q = (PHYS - s) / p;
    return (q > MAXV) ? MAXV : q;
  endfunction

  // Checks one access against the arithmetic model; caller samples mid-cycle.
  task automatic chk_access(input int s, input int p, input int cnt, input int v, input int r);
    int e_idx;
    bit e_val;
    bit e_err;
    string tag;
    vp_slot = 7'(v);
    log_reg = 5'(r);
    #0.2;
    if (v >= cnt || r >= s + p) begin
      e_err = 1'b1; e_val = 1'b0; e_idx = 0; tag = "R7";
    end else if (r < s) begin
      e_err = 1'b0; e_val = 1'b1; e_idx = r; tag = "R5";
    end else begin
      e_err = 1'b0; e_val = 1'b1; e_idx = s + v * p + (r - s); tag = "R6";
    end
    chk({tag, " idx"},   int'(phys_idx),  e_idx);
    chk({tag, " valid"}, int'(idx_valid), int'(e_val));
    chk({tag, " err"},   int'(acc_err),   int'(e_err));
  endtask

  // Write a configuration and track the ready timing edge by edge.
  task automatic cfg_write(input int s, input int p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_shared = 6'(s); cfg_private = 6'(p);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R4 pulse", int'(state_lost), 1);
    chk("R3 busy", int'(cfg_ready), 0);
    vp_slot = '0; log_reg = '0;
    #0.2;
    chk("R8 valid", int'(idx_valid), 0);
    chk("R8 err", int'(acc_err), 0);
    chk("R8 idx", int'(phys_idx), 0);
    for (int k = 1; k < STEPS; k++) begin
      @(negedge clk);
      chk("R3 busy", int'(cfg_ready), 0);
      if (k == 1) chk("R4 single", int'(state_lost), 0);
    end
    @(negedge clk);
    chk("R3 ready", int'(cfg_ready), 1);
    chk("R2 count", int'(vp_count), exp_count(s, p));
  endtask

  task automatic sweep(input int s, input int p);
    int cnt;
    int top;
    cnt = exp_count(s, p);
    top = (cnt + 1 > MAXV - 1) ? MAXV - 1 : cnt + 1;
    for (int v = 0; v <= top; v++) begin
      @(negedge clk);
      for (int r = 0; r < PHYS; r++) chk_access(s, p, cnt, v, r);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int plist[14];
    rst_n = 1'b0; cfg_we = 1'b0; cfg_shared = '0; cfg_private = '0;
    vp_slot = '0; log_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset configuration
    chk("R1 count", int'(vp_count), 4);
    chk("R1 ready", int'(cfg_ready), 1);
    chk("R1 lost", int'(state_lost), 0);
    chk_access(0, 8, 4, 3, 7);
    chk_access(0, 8, 4, 4, 0);

    // R9: output follows the input within the same cycle
    @(negedge clk);
    vp_slot = 7'd1; log_reg = 5'd2;
    #0.2;
    chk("R9 idx", int'(phys_idx), 10);
    log_reg = 5'd5;
    #0.2;
    chk("R9 idx", int'(phys_idx), 13);

    // R3: restart on a write while busy
    @(negedge clk);
    cfg_we = 1'b1; cfg_shared = 6'd0; cfg_private = 6'd4;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R3 busy", int'(cfg_ready), 0);
    cfg_write(4, 4);
    chk("R2 restart count", int'(vp_count), 7);
    sweep(4, 4);

    // Near-exhaustive sweep of the configuration space
    plist = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 16, 31, 32, 33};
    for (int s = 0; s <= 34; s++) begin
      foreach (plist[i]) begin
        cfg_write(s, plist[i]);
        sweep(s, plist[i]);
      end
    end
    cfg_write(63, 63);
    sweep(63, 63);

    // R7: highest slot number
    cfg_write(0, 1);
    @(negedge clk);
    chk_access(0, 1, 32, 127, 0);

    // R2: count holds with no write
    repeat (5) @(negedge clk);
    chk("R2 hold", int'(vp_count), 32);
    chk("R4 idle", int'(state_lost), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule